// File: doc/BRIEF.md
# Incrementing Pattern Self-Test Generator and Verifier

This block provides both ends of a built-in self-test for a parallel transceiver datapath. On the transmit side, a generator sends a word on every cycle, and each word is one more than the word before it. On the receive side, a verifier watches a parallel bus that carries a valid qualifier. It waits until it sees a zero word, which it treats as the start of the sequence. From that point on it compares every valid word with the value it expects next. It sets two sticky outputs. The done flag rises after one full wrap of the pattern or after the first mismatch. The error flag rises only on a mismatch.

Each side has its own reset, so either end can be restarted without disturbing the other. The verifier locks only on the zero word, so any amount of link latency between the two sides is tolerated. Once done is set, the verifier makes no further comparisons. Both flags then hold their value until the receive-side reset is applied.

Top module: `bist_inc_top`

## Requirements
- R1: While tx_rst_ni is low, tx_data_o is 0 and tx_valid_o is 0.
- R2: After tx_rst_ni is released, tx_valid_o stays high. tx_data_o starts at 0, rises by one on every cycle and wraps from 2**DATA_W-1 back to 0.
- R3: Until the verifier has seen a valid word equal to 0, it ignores every valid word, and rx_done_o and rx_err_o stay low.
- R4: A cycle with rx_valid_i low has no effect: neither flag changes, and the expected value does not advance.
- R5: Once locked, if the verifier receives 2**DATA_W consecutive correct valid words (the lock word 0 counts as the first), rx_done_o rises on the cycle after the last of them and rx_err_o stays low. rx_done_o is still low after 2**DATA_W-1 correct words.
- R6: Once locked, a valid word that does not equal the previous valid word plus one (modulo 2**DATA_W) sets rx_err_o and rx_done_o on the next cycle.
- R7: Once rx_done_o is high, neither flag changes until rx_rst_ni is applied, whatever data arrives.
- R8: Asserting rx_rst_ni low clears both flags and the lock, and it does not disturb the generator. Asserting tx_rst_ni low does not change the verifier flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| tx_rst_ni | input | 1 | Active-low asynchronous reset, generator side |
| rx_rst_ni | input | 1 | Active-low asynchronous reset, verifier side |
| tx_data_o | output | DATA_W | Generated pattern word |
| tx_valid_o | output | 1 | Generated word is valid |
| rx_data_i | input | DATA_W | Received word |
| rx_valid_i | input | 1 | Received word qualifier |
| rx_done_o | output | 1 | Sticky: full wrap seen or error found |
| rx_err_o | output | 1 | Sticky: mismatch found |

## Verification
The bench uses the default DATA_W of 8. At that width a full 256-word wrap fits easily within the run, so the exact cycle on which done rises can be checked against a count of correct words. A delay line of five cycles between the two sides shows that lock is independent of latency. A receive-side reset released in the middle of the pattern shows that the verifier seeks the next zero word before it starts comparing. Words driven directly into the receive side cover the remaining cases: words before lock, gaps in the valid qualifier, mismatches, and the freeze after done.

// File: rtl/bist_inc_pkg.sv
package bist_inc_pkg;
  typedef enum logic {
    TRK_SEEK  = 1'b0,
    TRK_TRACK = 1'b1
  } trk_state_e;
endpackage

// File: rtl/bist_inc_gen.sv
module bist_inc_gen #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  // first cycle out of reset sends 0, then counts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      valid_q <= 1'b1;
    end else begin
      data_q <= data_q + 1'b1;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/bist_inc_trk.sv
module bist_inc_trk
  import bist_inc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              hold_i,
  output logic              last_o,
  output logic              miss_o
);
  localparam logic [DATA_W-1:0] TOP_VAL = {DATA_W{1'b1}};

  trk_state_e        state_q, state_d;
  logic [DATA_W-1:0] exp_q, exp_d;
  logic              take, hit;

  assign take = valid_i && !hold_i;

  always_comb begin
    state_d = state_q;
    exp_d   = exp_q;
    hit     = 1'b0;
    miss_o  = 1'b0;
    if (take) begin
      unique case (state_q)
        TRK_SEEK: begin
          if (data_i == '0) begin
            hit     = 1'b1;
            state_d = TRK_TRACK;
            exp_d   = data_i + 1'b1;
          end
        end
        TRK_TRACK: begin
          if (data_i == exp_q) begin
            hit   = 1'b1;
            exp_d = exp_q + 1'b1;
          end else begin
            miss_o = 1'b1;
          end
        end
        default: state_d = TRK_SEEK;
      endcase
    end
  end

  // locked at 0, so the top value marks the last of a full wrap
  assign last_o = hit && (data_i == TOP_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRK_SEEK;
      exp_q   <= '0;
    end else begin
      state_q <= state_d;
      exp_q   <= exp_d;
    end
  end
endmodule

// File: rtl/bist_inc_flags.sv
module bist_inc_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic last_i,
  input  logic miss_i,
  output logic done_o,
  output logic err_o
);
  logic done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (!done_q) begin
      done_q <= last_i || miss_i;
      err_q  <= miss_i;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/bist_inc_top.sv
module bist_inc_top #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              tx_rst_ni,
  input  logic              rx_rst_ni,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_done_o,
  output logic              rx_err_o
);
  logic last, miss;

  bist_inc_gen #(.DATA_W(DATA_W)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (tx_rst_ni),
    .data_o  (tx_data_o),
    .valid_o (tx_valid_o)
  );

  bist_inc_trk #(.DATA_W(DATA_W)) u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rx_rst_ni),
    .data_i  (rx_data_i),
    .valid_i (rx_valid_i),
    .hold_i  (rx_done_o),
    .last_o  (last),
    .miss_o  (miss)
  );

  bist_inc_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rx_rst_ni),
    .last_i (last),
    .miss_i (miss),
    .done_o (rx_done_o),
    .err_o  (rx_err_o)
  );
endmodule

// File: rtl/bist_inc_sva.sv
module bist_inc_sva #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              tx_rst_ni,
  input logic              rx_rst_ni,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_valid_o,
  input logic              rx_valid_i,
  input logic              rx_done_o,
  input logic              rx_err_o
);
  a_r1_gen_reset: assert property (@(posedge clk_i)
    !tx_rst_ni |-> (tx_data_o == '0 && !tx_valid_o));

  a_r2_gen_step: assert property (@(posedge clk_i) disable iff (!tx_rst_ni)
    (tx_valid_o && $past(tx_valid_o)) |-> tx_data_o == DATA_W'($past(tx_data_o) + 1'b1));

  a_r2_valid_held: assert property (@(posedge clk_i) disable iff (!tx_rst_ni)
    tx_valid_o |=> tx_valid_o);

  a_r4_idle_no_change: assert property (@(posedge clk_i) disable iff (!rx_rst_ni)
    !rx_valid_i |=> ($stable(rx_done_o) && $stable(rx_err_o)));

  a_r6_err_implies_done: assert property (@(posedge clk_i) disable iff (!rx_rst_ni)
    rx_err_o |-> rx_done_o);

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rx_rst_ni)
    rx_done_o |=> (rx_done_o && $stable(rx_err_o)));
endmodule

bind bist_inc_top bist_inc_sva #(.DATA_W(DATA_W)) u_sva (
  .clk_i      (clk_i),
  .tx_rst_ni  (tx_rst_ni),
  .rx_rst_ni  (rx_rst_ni),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .rx_valid_i (rx_valid_i),
  .rx_done_o  (rx_done_o),
  .rx_err_o   (rx_err_o)
);

// File: tb/bist_inc_top_test.sv
module bist_inc_top_test;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SPAN   = 1 << DATA_W;
  localparam int unsigned DLY    = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              tx_rst_n = 1'b0;
  logic              rx_rst_n = 1'b0;
  logic [DATA_W-1:0] tx_data;
  logic              tx_valid;
  logic [DATA_W-1:0] drv_data = '0;
  logic              drv_valid = 1'b0;
  logic              use_loop = 1'b0;
  logic              rx_done, rx_err;

  logic [DATA_W:0] dly_q [DLY];
  always_ff @(posedge clk) begin
    dly_q[0] <= {tx_valid, tx_data};
    for (int i = 1; i < DLY; i++) dly_q[i] <= dly_q[i-1];
  end

  logic [DATA_W-1:0] rx_data;
  logic              rx_valid;
  assign rx_data  = use_loop ? dly_q[DLY-1][DATA_W-1:0] : drv_data;
  assign rx_valid = use_loop ? dly_q[DLY-1][DATA_W]     : drv_valid;

  bist_inc_top #(.DATA_W(DATA_W)) uut (
    .clk_i      (clk),
    .tx_rst_ni  (tx_rst_n),
    .rx_rst_ni  (rx_rst_n),
    .tx_data_o  (tx_data),
    .tx_valid_o (tx_valid),
    .rx_data_i  (rx_data),
    .rx_valid_i (rx_valid),
    .rx_done_o  (rx_done),
    .rx_err_o   (rx_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input int d, input bit v);
    @(negedge clk);
    drv_data  = DATA_W'(d);
    drv_valid = v;
    tick();
  endtask

  task automatic rx_restart();
    @(negedge clk); rx_rst_n = 1'b0; drv_valid = 1'b0;
    tick();
    @(negedge clk); rx_rst_n = 1'b1;
  endtask

  task automatic t_reset();
    tick(); tick();
    check("R1 tx_data in reset", tx_data, 0);
    check("R1 tx_valid in reset", tx_valid, 0);
    check("R8 done in reset", rx_done, 0);
    check("R8 err in reset", rx_err, 0);
  endtask

  task automatic t_gen();
    int bad = 0;
    @(negedge clk); tx_rst_n = 1'b1;
    for (int i = 0; i < SPAN + 40; i++) begin
      tick();
      if (!tx_valid || tx_data != DATA_W'(i)) bad++;
    end
    check("R2 incrementing stream with wrap", bad, 0);
  endtask

  task automatic t_prelock_and_wrap();
    rx_restart();
    send(5, 1); send(9, 1); send(255, 1); send(1, 1);
    check("R3 no flags before lock (done)", rx_done, 0);
    check("R3 no flags before lock (err)", rx_err, 0);
    for (int i = 0; i < SPAN - 1; i++) begin
      send(i, 1);
      if (i % 37 == 3) send(77, 0);
    end
    check("R4 gaps ignored, err low", rx_err, 0);
    check("R5 not done after SPAN-1 words", rx_done, 0);
    send(SPAN - 1, 1);
    check("R5 done after full wrap", rx_done, 1);
    check("R5 err low after full wrap", rx_err, 0);
    send(42, 1); send(3, 1);
    check("R7 done held", rx_done, 1);
    check("R7 err not set after done", rx_err, 0);
  endtask

  task automatic t_mismatch();
    rx_restart();
    check("R8 done cleared by rx reset", rx_done, 0);
    send(0, 1); send(1, 1); send(2, 1);
    check("R6 no err on good words", rx_err, 0);
    send(7, 1);
    check("R6 err on mismatch", rx_err, 1);
    check("R6 done on mismatch", rx_done, 1);
    send(8, 1); send(0, 1);
    check("R7 err frozen", rx_err, 1);
    check("R7 done frozen", rx_done, 1);
    rx_restart();
    tick();
    check("R8 err cleared", rx_err, 0);
    check("R8 generator undisturbed", tx_valid, 1);
  endtask

  task automatic t_loop();
    int cyc = 0;
    @(negedge clk); use_loop = 1'b1; rx_rst_n = 1'b0;
    tick(); tick();
    @(negedge clk); rx_rst_n = 1'b1;
    while (!rx_done && cyc < 3 * SPAN) begin tick(); cyc++; end
    check("R5 loopback done reached", rx_done, 1);
    check("R5 loopback bound", int'(cyc <= 2 * SPAN + DLY + 2), 1);
    check("R3 loopback err low", rx_err, 0);
    @(negedge clk); tx_rst_n = 1'b0;
    tick(); tick();
    @(negedge clk); tx_rst_n = 1'b1;
    for (int i = 0; i < 20; i++) tick();
    check("R8 tx reset leaves done", rx_done, 1);
    check("R8 tx reset leaves err", rx_err, 0);
  endtask

  initial begin
    t_reset();
    t_gen();
    t_prelock_and_wrap();
    t_mismatch();
    t_loop();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2ms;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule